// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small 8-bit microcontroller core goes to sleep and when it wakes up. The core pulses a one-cycle strobe when it executes its halt-for-power-saving instruction. At that moment a single control-register bit picks one of two sleep modes. In deep stop, the oscillator and every clock it feeds are shut off. In timer idle, the oscillator keeps running, the two wake-capable timers keep counting and the prescaler runs only its slowest (divide-by-2048) tap, while the CPU clock is gated off.

The core's program counter only advances while the CPU clock enable is high. It therefore stays on the instruction after the halt for the whole time the block is out of the run state, and execution continues from there. The block never drives RAM, control registers or port registers, so their contents are left as they were.

Wake requests are asynchronous levels. They pass through a two-flop synchronizer on the always-running sense clock. Leaving deep stop first re-enables the oscillator and then waits a fixed settle window of 2^SETTLE_LOG2 cycles before the CPU clock returns. Leaving timer idle returns straight to the run state. A synchronous reset wins over every other input.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: The block leaves the run state only on a cycle where `stop_strobe` is high. A strobe seen while the block is in stop, idle or settle has no effect.
- R2: A strobe in run with `wake_sel`=0 moves the block to deep stop on the next edge. In deep stop, `osc_en`, `cpu_clk_en`, `tmr_clk_en`, `presc_en` and `presc_2048_only` are all 0.
- R3: A strobe in run with `wake_sel`=1 moves the block to timer idle on the next edge. In timer idle, `osc_en`=1, `cpu_clk_en`=0, `tmr_clk_en`=1, `presc_en`=1 and `presc_2048_only`=1.
- R4: In run, `osc_en`, `cpu_clk_en`, `tmr_clk_en` and `presc_en` are 1, and `presc_2048_only` is 0.
- R5: Deep stop is left for settle when any of `wake_in` bits 0 to 7 is high. Those bits are: bit 0 watchdog, bits 1 to 4 external interrupts 0 to 3, bits 5 and 6 event counters 0 and 1, bit 7 SPI. Bits 8 (Timer0) and 9 (Timer2) are ignored in deep stop.
- R6: Timer idle is left straight for run when any of `wake_in` bits 0 to 9 is high, including the two timer bits.
- R7: Settle lasts exactly 2^SETTLE_LOG2 cycles, then the block returns to run. During settle, `osc_en`=1 and the other four clock outputs are 0.
- R8: `rst_n` low at a rising edge puts the block in settle from any state and restarts the settle count. After release, run follows 2^SETTLE_LOG2 edges later.
- R9: `status` encodes the state as run=00, deep stop=01, timer idle=10, settle=11.
- R10: A change on `wake_in` takes effect at the third rising edge after it is applied, because of the two synchronizer flops.
- R11: `cpu_clk_en` is 1 only in run, so the program counter holds in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sense clock (low-rate RC) |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_strobe | input | 1 | One-cycle pulse when the halt instruction executes |
| wake_sel | input | 1 | Mode bit: 0 deep stop, 1 timer idle |
| wake_in | input | 10 | Asynchronous wake request levels (bit map in R5) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| tmr_clk_en | output | 1 | Timer0/Timer2 clock gate |
| presc_en | output | 1 | Prescaler clock gate |
| presc_2048_only | output | 1 | Prescaler restricted to its divide-by-2048 tap |
| status | output | 2 | Current state code (R9) |

## Verification
The assertions assume that `stop_strobe` and `wake_sel` are synchronous to `clk`, and that reset is the only way into settle other than a deep-stop wake. They check state transitions, not wake latency, so they do not depend on when the asynchronous `wake_in` bits arrive. The stimulus changes every input on the falling edge, holds each wake level for at least three rising edges so it gets through the synchronizer, and clears the wake bits before the next strobe.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the low-power sequencer: state codes, wake bit map,
// and the bundle of clock controls. Assumes a 10-bit wake vector.
package pwr_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_STOP   = 2'b01,
        ST_IDLE   = 2'b10,
        ST_SETTLE = 2'b11
    } pwr_state_e;

    localparam int WAKE_W  = 10;
    localparam int WK_TMR0 = 8;
    localparam int WK_TMR2 = 9;

    typedef struct packed {
        logic osc_en;
        logic cpu_clk_en;
        logic tmr_clk_en;
        logic presc_en;
        logic presc_2048_only;
    } clk_ctl_t;
endpackage

// File: rtl/pwr_wake_sync.sv
// Multi-stage level synchronizer, one chain per wake bit.
// Assumes STAGES >= 2; clears all stages under synchronous reset.
module pwr_wake_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw level through the chain for this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pwr_wake_filter.sv
// Reduces the synchronized wake vector to one request per sleep mode.
// Timer bits are masked out of the deep-stop request.
module pwr_wake_filter
    import pwr_seq_pkg::*;
#(
    parameter int W = WAKE_W
) (
    input  logic [W-1:0] wake_s,
    output logic         stop_wake,
    output logic         idle_wake
);
    logic [W-1:0] stop_mask;

    for (genvar b = 0; b < W; b++) begin : g_mask
        assign stop_mask[b] = (b != WK_TMR0) && (b != WK_TMR2);
    end

    // Any source ends idle; only non-timer sources end deep stop.
    always_comb begin
        idle_wake = |wake_s;
        stop_wake = |(wake_s & stop_mask);
    end
endmodule

// File: rtl/pwr_settle_cnt.sv
// Oscillator settle counter: runs while enabled, clears otherwise,
// and flags the last cycle of a 2^LOG2-cycle window.
module pwr_settle_cnt #(
    parameter int LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_cnt,
    output logic done
);
    logic [LOG2-1:0] cnt;

    // Count settle cycles; restart from zero outside settle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (run_cnt) cnt <= cnt + 1'b1;
        else              cnt <= '0;
    end

    assign done = &cnt;
endmodule

// File: rtl/pwr_seq_fsm.sv
// Four-state sleep sequencer. Reset forces settle; the strobe is only
// honoured in run. Assumes the wake requests are already synchronized.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_strobe,
    input  logic       wake_sel,
    input  logic       stop_wake,
    input  logic       idle_wake,
    input  logic       settle_done,
    output pwr_state_e state
);
    pwr_state_e nxt;

    // Next-state selection per current state.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (stop_strobe) nxt = wake_sel ? ST_IDLE : ST_STOP;
            ST_STOP:   if (stop_wake)   nxt = ST_SETTLE;
            ST_IDLE:   if (idle_wake)   nxt = ST_RUN;
            ST_SETTLE: if (settle_done) nxt = ST_RUN;
            default:                    nxt = ST_SETTLE;
        endcase
    end

    // State register; reset lands in settle so the oscillator can start.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/pwr_clk_decode.sv
// Maps the sequencer state onto the oscillator, clock gate and
// prescaler controls. Purely combinational.
module pwr_clk_decode
    import pwr_seq_pkg::*;
(
    input  pwr_state_e state,
    output clk_ctl_t   ctl
);
    // One control pattern per state.
    always_comb begin
        unique case (state)
            ST_RUN:    ctl = '{osc_en: 1'b1, cpu_clk_en: 1'b1, tmr_clk_en: 1'b1,
                               presc_en: 1'b1, presc_2048_only: 1'b0};
            ST_IDLE:   ctl = '{osc_en: 1'b1, cpu_clk_en: 1'b0, tmr_clk_en: 1'b1,
                               presc_en: 1'b1, presc_2048_only: 1'b1};
            ST_SETTLE: ctl = '{osc_en: 1'b1, cpu_clk_en: 1'b0, tmr_clk_en: 1'b0,
                               presc_en: 1'b0, presc_2048_only: 1'b0};
            default:   ctl = '0;
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the low-power sequencer. Synchronizes the wake sources,
// sequences sleep entry/exit and drives the clock controls.
// Assumes clk is the always-running sense clock.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NWAKE       = WAKE_W,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_strobe,
    input  logic             wake_sel,
    input  logic [NWAKE-1:0] wake_in,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             tmr_clk_en,
    output logic             presc_en,
    output logic             presc_2048_only,
    output logic [1:0]       status
);
    logic [NWAKE-1:0] wake_s;
    logic             stop_wake;
    logic             idle_wake;
    logic             settle_done;
    pwr_state_e       state;
    clk_ctl_t         ctl;

    pwr_wake_sync #(.W(NWAKE), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(wake_in), .q_sync(wake_s)
    );

    pwr_wake_filter #(.W(NWAKE)) u_filt (
        .wake_s(wake_s), .stop_wake(stop_wake), .idle_wake(idle_wake)
    );

    pwr_settle_cnt #(.LOG2(SETTLE_LOG2)) u_settle (
        .clk(clk), .rst_n(rst_n), .run_cnt(state == ST_SETTLE),
        .done(settle_done)
    );

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe),
        .wake_sel(wake_sel), .stop_wake(stop_wake), .idle_wake(idle_wake),
        .settle_done(settle_done), .state(state)
    );

    pwr_clk_decode u_dec (.state(state), .ctl(ctl));

    assign osc_en          = ctl.osc_en;
    assign cpu_clk_en      = ctl.cpu_clk_en;
    assign tmr_clk_en      = ctl.tmr_clk_en;
    assign presc_en        = ctl.presc_en;
    assign presc_2048_only = ctl.presc_2048_only;
    assign status          = state;
endmodule

// File: rtl/pwr_seq_chk.sv
// Property checker for the low-power sequencer, bound to the top.
// Keeps its own settle-length counter to check the window.
module pwr_seq_chk #(
    parameter int SETTLE_LOG2 = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_strobe,
    input logic       wake_sel,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic       tmr_clk_en,
    input logic       presc_en,
    input logic       presc_2048_only,
    input logic [1:0] status
);
    localparam logic [1:0] S_RUN = 2'b00, S_STOP = 2'b01,
                           S_IDLE = 2'b10, S_SETTLE = 2'b11;
    localparam logic [SETTLE_LOG2-1:0] LAST = '1;

    logic [SETTLE_LOG2-1:0] sl_cnt;

    // Count consecutive settle cycles seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sl_cnt <= '0;
        else if (status == S_SETTLE) sl_cnt <= sl_cnt + 1'b1;
        else                         sl_cnt <= '0;
    end

    AST_ENTRY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_RUN && !stop_strobe) |=> status == S_RUN); // R1
    AST_MODE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_RUN && stop_strobe && !wake_sel) |=> status == S_STOP); // R2
    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_RUN && stop_strobe && wake_sel) |=> status == S_IDLE); // R3
    AST_STOP_CLKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        status == S_STOP |-> !(osc_en || cpu_clk_en || tmr_clk_en || presc_en || presc_2048_only)); // R2
    AST_IDLE_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        status == S_IDLE |-> (osc_en && !cpu_clk_en && tmr_clk_en && presc_en && presc_2048_only)); // R3
    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        status == S_STOP |=> (status == S_STOP || status == S_SETTLE)); // R5
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        status == S_IDLE |=> (status == S_IDLE || status == S_RUN)); // R6
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_SETTLE && sl_cnt != LAST) |=> status == S_SETTLE); // R7
    AST_SETTLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_SETTLE && sl_cnt == LAST) |=> status == S_RUN); // R7
    AST_RESET_SETTLE: assert property (@(posedge clk)
        !rst_n |=> status == S_SETTLE); // R8
    AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        status != S_RUN |-> !cpu_clk_en); // R11
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.SETTLE_LOG2(SETTLE_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .wake_sel(wake_sel),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
    .presc_en(presc_en), .presc_2048_only(presc_2048_only), .status(status)
);

// File: tb/pwr_seq_ctrl_test.sv
// Self-checking bench: vector table of sleep/wake scenarios, then
// directed checks for reset, settle length, latency and ignored strobes.
module pwr_seq_ctrl_test;
    localparam int SL = 4;
    localparam int SETTLE_CYC = 1 << SL;
    localparam logic [1:0] RUN = 2'b00, STP = 2'b01, IDL = 2'b10, SET = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_strobe = 1'b0;
    logic       wake_sel = 1'b0;
    logic [9:0] wake_in = '0;
    logic       osc_en, cpu_clk_en, tmr_clk_en, presc_en, presc_2048_only;
    logic [1:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pwr_seq_ctrl #(.SETTLE_LOG2(SL)) uut (
        .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .wake_sel(wake_sel),
        .wake_in(wake_in), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
        .tmr_clk_en(tmr_clk_en), .presc_en(presc_en),
        .presc_2048_only(presc_2048_only), .status(status)
    );

    always #10 clk = ~clk;

    // Table row: {sel, wake[9:0], status after strobe, status after wake}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 10'b0000000001, STP, SET},   // R5 watchdog
        {1'b0, 10'b0000000010, STP, SET},   // R5 ext irq 0
        {1'b0, 10'b0000010000, STP, SET},   // R5 ext irq 3
        {1'b0, 10'b0010000000, STP, SET},   // R5 SPI
        {1'b0, 10'b0100000000, STP, STP},   // R5 Timer0 ignored
        {1'b0, 10'b1000000000, STP, STP},   // R5 Timer2 ignored
        {1'b1, 10'b0100000000, IDL, RUN},   // R6 Timer0
        {1'b1, 10'b1000000000, IDL, RUN},   // R6 Timer2
        {1'b1, 10'b0000100000, IDL, RUN},   // R6 event counter 0
        {1'b1, 10'b0000000000, IDL, IDL}    // R6 no source
    };

    // Expected {osc, cpu, tmr, presc, only} per state code (R2 R3 R4 R7 R11).
    function automatic logic [4:0] exp_ctl(input logic [1:0] st);
        case (st)
            RUN:     return 5'b11110;
            STP:     return 5'b00000;
            IDL:     return 5'b10111;
            default: return 5'b10000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [1:0] exp);
        chk({req, " status"}, {3'b000, status}, {3'b000, exp});
        chk({req, " clocks"}, {osc_en, cpu_clk_en, tmr_clk_en, presc_en, presc_2048_only},
            exp_ctl(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stop_strobe = 1'b0; wake_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (SETTLE_CYC) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter(input logic sel);
        stop_strobe = 1'b1; wake_sel = sel;
        @(posedge clk);
        @(negedge clk);
        stop_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8 R9: state held in settle during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_state("R8 reset", SET);
        rst_n = 1'b1;
        // R7: settle lasts exactly 2^SL edges after release
        repeat (SETTLE_CYC - 1) @(posedge clk);
        @(negedge clk);
        chk_state("R7 settle last", SET);
        @(posedge clk);
        @(negedge clk);
        chk_state("R4 run", RUN);

        // Table walk: R2 R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            do_reset();
            enter(VEC[i][14]);
            chk_state("R2/R3 entry", VEC[i][3:2]);
            wake_in = VEC[i][13:4];
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk_state("R5/R6 wake", VEC[i][1:0]);
            wake_in = '0;
        end

        // R10: two edges after a wake level the block still idles
        do_reset();
        enter(1'b1);
        wake_in = 10'b0000001000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_state("R10 sync edge2", IDL);
        @(posedge clk);
        @(negedge clk);
        chk_state("R10 sync edge3", RUN);
        wake_in = '0;

        // R1: strobe in idle is ignored
        do_reset();
        enter(1'b1);
        enter(1'b0);
        chk_state("R1 strobe in idle", IDL);

        // R1: no strobe keeps run
        do_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_state("R1 no strobe", RUN);

        // R7 R11: deep-stop wake settles 2^SL cycles, strobe ignored meanwhile
        do_reset();
        enter(1'b0);
        wake_in = 10'b0001000000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wake_in = '0;
        chk_state("R7 settle entry", SET);
        enter(1'b1);
        chk_state("R1 strobe in settle", SET);
        repeat (SETTLE_CYC - 2) @(posedge clk);
        @(negedge clk);
        chk_state("R7 settle end", SET);
        @(posedge clk);
        @(negedge clk);
        chk_state("R7 back to run", RUN);

        // R8: reset from deep stop goes to settle
        do_reset();
        enter(1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_state("R8 reset from stop", SET);
        rst_n = 1'b1;

        finish_run();
    end
endmodule